// File: doc/BRIEF.md
# Three-Wire Serial Clock Chip Bus Master

This block drives single-byte register transfers to a real-time-clock chip over a three-wire link. The link has an enable line that frames each transfer, a serial clock, and one shared data line. Inside the chip, the shared data line is split into an output, an output enable and an input.

A host raises `req_valid` for one cycle while the block is idle. With it, the host gives the direction, a region select (clock registers or RAM), a 5-bit register index and, for writes, a data byte. The block forms the command byte and clocks it out least-significant bit first. It then clocks out the data byte, or releases the line and clocks the device's reply in. It ends the frame with the serial clock low and the enable line dropped. It then pulses `done`, and after a reads `rdata` holds the returned byte. The serial clock half-period is the parameter `HALF_DIV`, counted in system clocks.

Top module: `rtc3w_master`

## Requirements
- R1: After reset, `rtc_ce`, `rtc_sclk`, `rtc_doe`, `busy` and `done` are all 0.
- R2: When `rtc_ce` rises, `rtc_sclk` is already low and the master is already driving the first command bit (`rtc_doe` = 1).
- R3: The command byte is sent least-significant bit first. Bit 0 is 1 for a read and 0 for a write. Bits 5:1 carry `req_addr`. Bit 6 is `req_ram` (1 = RAM, 0 = clock registers). Bit 7 is always 1. `rtc_dout` holds steady while `rtc_sclk` is high.
- R4: A write sends `req_wdata` least-significant bit first right after the command. Every frame has exactly 16 rising serial-clock edges.
- R5: On a read, `rtc_doe` drops at the falling edge that follows rising edge 8. `rtc_din` is sampled in the last system cycle before each of rising edges 9 to 16, least-significant bit first. The byte is valid on `rdata` from the cycle `done` is high. The master never drives the line while the device does, and never drives it outside a frame.
- R6: Inside a frame, every serial-clock phase lasts exactly `HALF_DIV` system clocks. This includes the time from `rtc_ce` rising to the first rising edge, and from the last falling edge to `rtc_ce` falling.
- R7: A frame ends with `rtc_sclk` low. `rtc_ce` then falls in the same cycle as a single-cycle `done` pulse.
- R8: `busy` is high from acceptance until at least 2×`HALF_DIV` cycles after `rtc_ce` falls. A request made while busy is ignored and starts no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_read | input | 1 | 1 = read, 0 = write |
| req_ram | input | 1 | 1 = RAM region, 0 = clock registers |
| req_addr | input | 5 | Register index within the region |
| req_wdata | input | 8 | Byte to write |
| busy | output | 1 | Transfer or gap in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| rdata | output | 8 | Last byte read |
| rtc_ce | output | 1 | Frame enable to the device |
| rtc_sclk | output | 1 | Serial clock |
| rtc_dout | output | 1 | Data driven onto the shared line |
| rtc_doe | output | 1 | Output enable for the shared line |
| rtc_din | input | 1 | Data read from the shared line |

## Verification
A wrong bit counter or shift position shows up in the device model's captured command within the same frame. It gives a misaddressed write, a rising-edge count other than 16, or a corrupted byte read back one transfer later. A phase counter that is off by one changes the measured distance between serial-clock edges on the very next edge. A late or missing output release shows up as bus contention on the first device-driven bit, at the falling edge after rising edge 8. A state machine that fails to guard `busy` starts a second frame when the request is dropped mid-transfer. That second frame is visible as an extra `rtc_ce` rise and a changed RAM location.

// File: rtl/rtc3w_master.sv
module rtc3w_master #(
  parameter int HALF_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       req_read,
  input  logic       req_ram,
  input  logic [4:0] req_addr,
  input  logic [7:0] req_wdata,
  output logic       busy,
  output logic       done,
  output logic [7:0] rdata,
  output logic       rtc_ce,
  output logic       rtc_sclk,
  output logic       rtc_dout,
  output logic       rtc_doe,
  input  logic       rtc_din
);
  localparam int GAP_N = 2 * HALF_DIV;
  localparam int CW = $clog2(GAP_N + 1);
  localparam logic [CW-1:0] HALF_END = CW'(HALF_DIV - 1);
  localparam logic [CW-1:0] GAP_END = CW'(GAP_N - 1);

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_HOLD, S_GAP} st_t;
  st_t st;
  logic [CW-1:0] cnt;
  logic [4:0] bitn;
  logic [15:0] sh;
  logic is_rd;
  logic [7:0] cmd;

  assign cmd  = {1'b1, req_ram, req_addr, req_read};
  assign busy = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; bitn <= '0; sh <= '0; is_rd <= 1'b0;
      rdata <= '0; done <= 1'b0; rtc_ce <= 1'b0; rtc_sclk <= 1'b0;
      rtc_dout <= 1'b0; rtc_doe <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          rtc_ce   <= 1'b1;
          rtc_sclk <= 1'b0;
          rtc_doe  <= 1'b1;
          rtc_dout <= cmd[0];
          sh       <= {req_wdata, cmd};
          is_rd    <= req_read;
          bitn     <= '0;
          cnt      <= '0;
          st       <= S_XFER;
        end
        S_XFER: if (cnt == HALF_END) begin
          cnt <= '0;
          if (!rtc_sclk) begin
            rtc_sclk <= 1'b1;
            if (is_rd && bitn[3]) rdata <= {rtc_din, rdata[7:1]};
          end else begin
            rtc_sclk <= 1'b0;
            bitn     <= bitn + 5'd1;
            sh       <= sh >> 1;
            rtc_dout <= sh[1];
            if (bitn == 5'd15) begin
              rtc_doe <= 1'b0;
              st      <= S_HOLD;
            end else if (is_rd && bitn == 5'd7) begin
              rtc_doe <= 1'b0;
            end
          end
        end else cnt <= cnt + 1'b1;
        S_HOLD: if (cnt == HALF_END) begin
          cnt    <= '0;
          rtc_ce <= 1'b0;
          done   <= 1'b1;
          st     <= S_GAP;
        end else cnt <= cnt + 1'b1;
        default: if (cnt == GAP_END) begin
          cnt <= '0;
          st  <= S_IDLE;
        end else cnt <= cnt + 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/rtc3w_master_chk.sv
module rtc3w_master_chk (
  input logic clk,
  input logic rst_n,
  input logic rtc_ce,
  input logic rtc_sclk,
  input logic rtc_dout,
  input logic rtc_doe,
  input logic busy,
  input logic done
);
  // R2
  ce_rise_sclk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rtc_ce) |-> (!rtc_sclk && rtc_doe));
  // R3
  dout_stable_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rtc_sclk && $past(rtc_sclk)) |-> $stable(rtc_dout));
  // R5
  doe_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rtc_doe |-> rtc_ce);
  // R7
  ce_fall_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rtc_ce) |-> (!rtc_sclk && !rtc_doe && done));
  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8
  busy_covers_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rtc_ce |-> busy);
endmodule

bind rtc3w_master rtc3w_master_chk chk_i (
  .clk(clk), .rst_n(rst_n), .rtc_ce(rtc_ce), .rtc_sclk(rtc_sclk),
  .rtc_dout(rtc_dout), .rtc_doe(rtc_doe), .busy(busy), .done(done)
);

// File: tb/rtc3w_master_tb_top.sv
module rtc3w_master_tb_top;
  localparam int HALF = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_read = 1'b0, req_ram = 1'b0;
  logic [4:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic busy, done, rtc_ce, rtc_sclk, rtc_dout, rtc_doe, rtc_din;
  logic [7:0] rdata;

  always #10 clk = ~clk;

  rtc3w_master #(.HALF_DIV(HALF)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_read(req_read),
    .req_ram(req_ram), .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rdata(rdata), .rtc_ce(rtc_ce),
    .rtc_sclk(rtc_sclk), .rtc_dout(rtc_dout), .rtc_doe(rtc_doe),
    .rtc_din(rtc_din)
  );

  int n_chk = 0, n_bad = 0;
  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // device model
  logic [7:0] mem [64];
  int dcnt = 0, frames = 0;
  logic [7:0] dcmd = '0, ddat = '0;
  logic ddrv = 1'b0, dq = 1'b0;
  assign rtc_din = ddrv ? dq : 1'b1;

  function automatic logic [7:0] init_val(int i);
    return 8'((i * 37) ^ 8'h5A);
  endfunction

  initial for (int i = 0; i < 64; i++) mem[i] = init_val(i);

  always @(posedge rtc_ce) begin dcnt = 0; dcmd = '0; ddat = '0; frames++; end
  always @(negedge rtc_ce) ddrv = 1'b0;
  always @(posedge rtc_sclk) if (rtc_ce) begin
    if (dcnt < 8) dcmd[dcnt] = rtc_dout;
    else if (!dcmd[0]) ddat[dcnt-8] = rtc_dout;
    if (dcnt == 15 && !dcmd[0] && dcmd[7]) mem[dcmd[6:1]] = ddat;
    dcnt++;
  end
  always @(negedge rtc_sclk) if (rtc_ce) begin
    if (dcmd[0] && dcnt >= 8 && dcnt < 16) begin
      ddrv = 1'b1; dq = mem[dcmd[6:1]][dcnt-8];
    end else ddrv = 1'b0;
  end

  // port monitor
  logic p_ce = 1'b0, p_sclk = 1'b0, seen_frame = 1'b0;
  int since = 0;
  bit bad_tim = 0, bad_r2 = 0, bad_r7 = 0, bad_oe = 0;
  always @(negedge clk) if (rst_n) begin
    if (rtc_ce != p_ce || rtc_sclk != p_sclk) begin
      if (p_ce && since != HALF) bad_tim = 1;
      if (rtc_ce && !p_ce) begin
        if (seen_frame && since < 2 * HALF) bad_tim = 1;
        if (rtc_sclk || !rtc_doe) bad_r2 = 1;
        seen_frame = 1;
      end
      if (!rtc_ce && p_ce && (!done || rtc_sclk)) bad_r7 = 1;
      since = 1;
    end else since++;
    if (done && !(p_ce && !rtc_ce)) bad_r7 = 1;
    if (ddrv && rtc_doe) bad_oe = 1;
    if (rtc_doe && !rtc_ce) bad_oe = 1;
    p_ce = rtc_ce; p_sclk = rtc_sclk;
  end

  task automatic xfer(bit rd, bit ram, logic [4:0] adr, logic [7:0] wd, logic [7:0] exp_rd);
    logic [7:0] exp_cmd;
    int t;
    exp_cmd = {1'b1, ram, adr, rd};
    bad_tim = 0; bad_r2 = 0; bad_r7 = 0; bad_oe = 0;
    @(negedge clk);
    req_valid = 1'b1; req_read = rd; req_ram = ram; req_addr = adr; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    t = 0;
    while (!done && t < 1000) begin @(negedge clk); t++; end
    chk(done, "R7", "done pulse seen", done, 1);
    if (rd) chk(rdata == exp_rd, "R5", "read byte", rdata, exp_rd);
    while (busy && t < 2000) begin @(negedge clk); t++; end
    chk(dcmd == exp_cmd, "R3", "command byte", dcmd, exp_cmd);
    chk(dcnt == 16, "R4", "rising edges", dcnt, 16);
    if (!rd) chk(ddat == wd, "R4", "written byte", ddat, wd);
    chk(!bad_tim, "R6", "phase timing", bad_tim, 0);
    chk(!bad_r2, "R2", "ce rise with sclk low", bad_r2, 0);
    chk(!bad_r7, "R7", "ce fall with done", bad_r7, 0);
    chk(!bad_oe, "R5", "line contention", bad_oe, 0);
  endtask

  // {ram, addr, data}
  localparam logic [13:0] VEC [6] = '{
    {1'b0, 5'd0,  8'h59}, {1'b0, 5'd6,  8'h24}, {1'b1, 5'd0,  8'hA5},
    {1'b1, 5'd31, 8'h3C}, {1'b1, 5'd17, 8'hFF}, {1'b0, 5'd7,  8'h00}
  };

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected <150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(!rtc_ce && !rtc_sclk && !rtc_doe && !busy && !done, "R1", "reset outputs",
        {rtc_ce, rtc_sclk, rtc_doe, busy, done}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!rtc_ce && !busy, "R1", "idle after release", {rtc_ce, busy}, 0);

    // untouched reads return preloaded content (R5)
    xfer(1, 1, 5'd9, 8'h00, init_val(32 + 9));
    xfer(1, 0, 5'd3, 8'h00, init_val(3));

    foreach (VEC[i]) xfer(0, VEC[i][13], VEC[i][12:8], VEC[i][7:0], 8'h00);
    foreach (VEC[i]) xfer(1, VEC[i][13], VEC[i][12:8], 8'h00, VEC[i][7:0]);

    // R8: request while busy is ignored
    begin
      int f0;
      logic [7:0] keep;
      keep = mem[32 + 20];
      f0 = frames;
      @(negedge clk);
      req_valid = 1'b1; req_read = 1'b0; req_ram = 1'b1; req_addr = 5'd2; req_wdata = 8'h11;
      @(negedge clk); req_valid = 1'b0;
      repeat (20) @(negedge clk);
      chk(busy, "R8", "busy mid frame", busy, 1);
      req_valid = 1'b1; req_ram = 1'b1; req_addr = 5'd20; req_wdata = 8'hEE;
      @(negedge clk); req_valid = 1'b0;
      repeat (200) @(negedge clk);
      chk(frames == f0 + 1, "R8", "frames started", frames - f0, 1);
      chk(mem[32 + 20] == keep, "R8", "ignored target unchanged", mem[32 + 20], keep);
      chk(mem[32 + 2] == 8'h11, "R4", "accepted write landed", mem[32 + 2], 8'h11);
    end
    xfer(1, 1, 5'd2, 8'h00, 8'h11);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule